// File: doc/BRIEF.md
# Indexed Effective-Address Unit

This block serves the indexed addressing mode of an 8-bit processor with a 16-bit address space. A `start` pulse hands it one addressing post byte together with the current X, Y, U, S, PC, A and B values. The block decodes the post byte and fetches any offset bytes that follow it in the instruction stream. For indirect forms it also reads a 16-bit pointer through a simple byte-wide read port. It then reports the final effective address with a one-cycle `done` strobe.

With `done` the block also presents the new value for the selected index register, which is used by the auto-increment and auto-decrement forms. It presents the advanced program counter as well. Encodings that are not defined raise `illegal` together with `done`, and the caller keeps all of its registers as they were. Using the address, the condition codes and interrupts are the caller's job.

Memory reads are combinational: when `mem_rd` is high, `mem_data` must hold the byte at `mem_addr` in the same cycle.

Top module: `idx_ea_unit`

## Requirements
- R1: Post-byte bits 6:5 choose the base register: 00 is X, 01 is Y, 10 is U, 11 is S. `idx_sel` carries these bits.
- R2: With bit 7 clear, the address is the base plus bits 4:0 as a signed value, with bit 4 as the sign. There is no memory read.
- R3: With bit 7 set, low nibble 0 and 1 give the base as the address and `idx_new` equal to base+1 or base+2. Nibble 2 and 3 give base-1 or base-2 as both the address and `idx_new`. `idx_wr` is high with `done` only for these four nibbles.
- R4: Nibble 4 adds zero. Nibble 5 adds B sign-extended, nibble 6 adds A sign-extended, and nibble B adds the unsigned 16-bit value {A,B}.
- R5: Nibble 8 adds one stream byte read at PC, taken as signed. Nibble 9 adds a 16-bit stream value, with the high byte at PC and the low byte at PC+1. `pc_new` is PC plus the number of bytes fetched.
- R6: Nibbles C and D act like 8 and 9, except that the base is the PC value after the offset bytes have been fetched.
- R7: When bit 7 and bit 4 are both set, the computed address points to a pointer. Its high byte is read there and its low byte at the next address, and the pointer becomes the final address. The index update of R3 still applies.
- R8: Nibble F with bit 4 set and bits 6:5 equal to 00 takes the final address from the pointer stored at the 16-bit stream address.
- R9: Nibbles 7, A and E are illegal, and so are nibble F other than in the form of R8 and the indirect forms of nibbles 0 and 2. Each raises `illegal` with `done` one cycle after `start`, with no memory read, `idx_wr` low and `pc_new` equal to the PC given.
- R10: `done` is a single-cycle pulse. It comes 2 + (offset bytes) + 2·(indirect) cycles after the `start` edge, and `start` is ignored while a decode is in progress.
- R11: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `post` (taken only when idle) |
| post | input | 8 | Addressing post byte |
| reg_x | input | 16 | X register |
| reg_y | input | 16 | Y register |
| reg_u | input | 16 | U register |
| reg_s | input | 16 | S register |
| reg_pc | input | 16 | PC, pointing at the byte after the post byte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, valid in the same cycle |
| done | output | 1 | Result valid, one cycle |
| illegal | output | 1 | Undefined encoding, high with `done` |
| ea | output | 16 | Effective address |
| idx_sel | output | 2 | Index register selected by the post byte |
| idx_wr | output | 1 | Write `idx_new` to the selected register |
| idx_new | output | 16 | Updated index register value |
| pc_new | output | 16 | PC after the offset bytes |

## Verification
Each result is due a fixed number of cycles after the `start` edge. That number is two, plus one per offset byte, plus two for an indirect pointer read. An illegal encoding is due after a single cycle. For every case the bench computes this count from the post byte alone. It counts rising edges until `done` is seen at a falling edge and checks that the count matches. Address, index and PC outputs are compared in that same falling-edge window. The next `start` is held back for one more cycle, so that it reaches the block while it is idle.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    post,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_u,
  input  logic [AW-1:0] reg_s,
  input  logic [AW-1:0] reg_pc,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  output logic          done,
  output logic          illegal,
  output logic [AW-1:0] ea,
  output logic [1:0]    idx_sel,
  output logic          idx_wr,
  output logic [AW-1:0] idx_new,
  output logic [AW-1:0] pc_new
);
  localparam int XW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_EXT1, S_EXT2, S_CALC, S_PTR1, S_PTR2, S_FIN} st_t;
  st_t st;

  logic [7:0]    pb;
  logic [AW-1:0] pc_r, base_r, ext_r, addr_r, ea_r, idx_r;
  logic [DW-1:0] a_r, b_r, hi_r;
  logic          ill_r, wr_r;

  logic [7:0] pbx;
  logic [3:0] nib;
  logic       ind, bad;
  logic [1:0] nx;
  logic [AW-1:0] sel_reg, offv, basev, sum;

  assign pbx = (st == S_IDLE) ? post : pb;
  assign nib = pbx[3:0];
  assign ind = pbx[7] & pbx[4];
  assign bad = pbx[7] & ((nib == 4'h7) | (nib == 4'hA) | (nib == 4'hE) |
               ((nib == 4'hF) & ~(ind & (pbx[6:5] == 2'b00))) |
               (ind & ((nib == 4'h0) | (nib == 4'h2))));
  assign nx = !pbx[7] ? 2'd0 :
              ((nib == 4'h8) | (nib == 4'hC)) ? 2'd1 :
              ((nib == 4'h9) | (nib == 4'hD) | (nib == 4'hF)) ? 2'd2 : 2'd0;

  always_comb begin
    case (post[6:5])
      2'b00:   sel_reg = reg_x;
      2'b01:   sel_reg = reg_y;
      2'b10:   sel_reg = reg_u;
      default: sel_reg = reg_s;
    endcase
  end

  always_comb begin
    offv = '0;
    if (!pb[7]) offv = {{(AW-5){pb[4]}}, pb[4:0]};
    else begin
      case (pb[3:0])
        4'h2:                offv = '1;
        4'h3:                offv = {{(AW-2){1'b1}}, 2'b10};
        4'h5:                offv = {{XW{b_r[DW-1]}}, b_r};
        4'h6:                offv = {{XW{a_r[DW-1]}}, a_r};
        4'h8, 4'hC:          offv = {{XW{ext_r[DW-1]}}, ext_r[DW-1:0]};
        4'h9, 4'hD, 4'hF:    offv = ext_r;
        4'hB:                offv = {a_r, b_r};
        default:             offv = '0;
      endcase
    end
  end

  assign basev = (pb[7] && (pb[3:0] == 4'hC || pb[3:0] == 4'hD)) ? pc_r :
                 (pb[7] && pb[3:0] == 4'hF) ? '0 : base_r;
  assign sum = basev + offv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pb <= '0; pc_r <= '0; base_r <= '0; ext_r <= '0; addr_r <= '0;
      ea_r <= '0; idx_r <= '0; a_r <= '0; b_r <= '0; hi_r <= '0;
      ill_r <= 1'b0; wr_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pb <= post; pc_r <= reg_pc; base_r <= sel_reg; idx_r <= sel_reg;
          a_r <= acc_a; b_r <= acc_b; ext_r <= '0; ea_r <= '0;
          ill_r <= bad; wr_r <= 1'b0;
          st <= bad ? S_FIN : (nx != 2'd0) ? S_EXT1 : S_CALC;
        end
        S_EXT1: begin
          ext_r <= {ext_r[AW-DW-1:0], mem_data};
          pc_r  <= pc_r + 1'b1;
          st    <= (nx == 2'd2) ? S_EXT2 : S_CALC;
        end
        S_EXT2: begin
          ext_r <= {ext_r[AW-DW-1:0], mem_data};
          pc_r  <= pc_r + 1'b1;
          st    <= S_CALC;
        end
        S_CALC: begin
          addr_r <= sum;
          if (pb[7] && pb[3:2] == 2'b00) begin
            wr_r  <= 1'b1;
            idx_r <= (pb[3:0] == 4'h0) ? base_r + 1'b1 :
                     (pb[3:0] == 4'h1) ? base_r + 2'd2 : sum;
          end
          if (ind) st <= S_PTR1;
          else begin
            ea_r <= sum;
            st   <= S_FIN;
          end
        end
        S_PTR1: begin
          hi_r <= mem_data;
          st   <= S_PTR2;
        end
        S_PTR2: begin
          ea_r <= {hi_r, mem_data};
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd   = (st == S_EXT1) | (st == S_EXT2) | (st == S_PTR1) | (st == S_PTR2);
  assign mem_addr = (st == S_PTR1) ? addr_r :
                    (st == S_PTR2) ? addr_r + 1'b1 : pc_r;
  assign done     = (st == S_FIN);
  assign illegal  = done & ill_r;
  assign idx_wr   = done & wr_r;
  assign ea       = ea_r;
  assign idx_new  = idx_r;
  assign idx_sel  = pb[6:5];
  assign pc_new   = pc_r;
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk (
  input logic clk,
  input logic rst_n,
  input logic mem_rd,
  input logic done,
  input logic illegal,
  input logic idx_wr
);
  assert_ill_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);
  assert_ill_no_idx_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !idx_wr);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_no_read_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !done);
  assert_idx_wr_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |-> done);
  assert_ill_no_read_before_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !$past(mem_rd));
endmodule

bind idx_ea_unit idx_ea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .done(done),
  .illegal(illegal), .idx_wr(idx_wr)
);

// File: tb/tb_idx_ea_unit.sv
module tb_idx_ea_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] post = '0, acc_a = '0, acc_b = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_u = '0, reg_s = '0, reg_pc = '0;
  logic mem_rd, done, illegal, idx_wr;
  logic [15:0] mem_addr, ea, idx_new, pc_new;
  logic [7:0] mem_data;
  logic [1:0] idx_sel;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_data = mem_fn(mem_addr);

  idx_ea_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .post(post),
    .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .done(done), .illegal(illegal), .ea(ea),
    .idx_sel(idx_sel), .idx_wr(idx_wr), .idx_new(idx_new), .pc_new(pc_new)
  );

  logic        e_ill, e_wr;
  logic [15:0] e_ea, e_idx, e_pc;
  int          e_lat;

  function automatic logic [15:0] sx8(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic model(input logic [7:0] p);
    logic [15:0] base, o;
    logic [3:0] nb;
    nb = p[3:0];
    case (p[6:5])
      2'd0: base = reg_x;
      2'd1: base = reg_y;
      2'd2: base = reg_u;
      default: base = reg_s;
    endcase
    e_pc = reg_pc; e_wr = 1'b0; e_idx = base; e_ill = 1'b0; e_ea = 16'h0;
    if (!p[7]) begin
      e_ea = base + {{11{p[4]}}, p[4:0]};
      e_lat = 2;
      return;
    end
    if (nb == 4'h7 || nb == 4'hA || nb == 4'hE ||
        (nb == 4'hF && !(p[4] && p[6:5] == 2'd0)) ||
        (p[4] && (nb == 4'h0 || nb == 4'h2))) begin
      e_ill = 1'b1; e_lat = 1;
      return;
    end
    e_lat = 2;
    case (nb)
      4'h0: begin e_ea = base; e_idx = base + 16'd1; e_wr = 1'b1; end
      4'h1: begin e_ea = base; e_idx = base + 16'd2; e_wr = 1'b1; end
      4'h2: begin e_ea = base - 16'd1; e_idx = e_ea; e_wr = 1'b1; end
      4'h3: begin e_ea = base - 16'd2; e_idx = e_ea; e_wr = 1'b1; end
      4'h4: e_ea = base;
      4'h5: e_ea = base + sx8(acc_b);
      4'h6: e_ea = base + sx8(acc_a);
      4'hB: e_ea = base + {acc_a, acc_b};
      4'h8, 4'hC: begin
        o = sx8(mem_fn(e_pc)); e_pc = e_pc + 16'd1; e_lat = 3;
        e_ea = (nb == 4'hC) ? e_pc + o : base + o;
      end
      default: begin
        o = {mem_fn(e_pc), mem_fn(e_pc + 16'd1)}; e_pc = e_pc + 16'd2; e_lat = 4;
        e_ea = (nb == 4'hD) ? e_pc + o : (nb == 4'hF) ? o : base + o;
      end
    endcase
    if (p[4]) begin
      e_ea = {mem_fn(e_ea), mem_fn(e_ea + 16'd1)};
      e_lat = e_lat + 2;
    end
  endtask

  task automatic check(input string tag, input string what, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] p, input string tag);
    int n;
    logic got;
    post = p; start = 1'b1;
    model(p);
    n = 0; got = 1'b0;
    for (int i = 0; i < 12 && !got; i++) begin
      @(posedge clk); n++;
      @(negedge clk); start = 1'b0;
      if (done) got = 1'b1;
    end
    check({tag, " R10"}, "latency", got && n == e_lat, n, e_lat);
    check({tag, " R9"}, "illegal", illegal == e_ill, illegal, e_ill);
    check({tag, " R5"}, "pc_new", pc_new == e_pc, pc_new, e_pc);
    check({tag, " R3"}, "idx_wr", idx_wr == e_wr, idx_wr, e_wr);
    check({tag, " R1"}, "idx_sel", idx_sel == p[6:5], idx_sel, p[6:5]);
    if (!e_ill) check(tag, "ea", ea == e_ea, ea, e_ea);
    if (e_wr) check({tag, " R3"}, "idx_new", idx_new == e_idx, idx_new, e_idx);
    @(negedge clk);
    check({tag, " R10"}, "done pulse", !done, done, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    reg_x = 16'h1000; reg_y = 16'h2000; reg_u = 16'h3000; reg_s = 16'h4000;
    reg_pc = 16'h8000; acc_a = 8'h80; acc_b = 8'h7F;
    repeat (3) @(negedge clk);
    check("R10 reset", "done", !done && !mem_rd && !illegal, {done, mem_rd, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 base selection
    run(8'h84, "R1 X"); run(8'hA4, "R1 Y"); run(8'hC4, "R1 U"); run(8'hE4, "R1 S");
    // R2 five-bit constant
    run(8'h0F, "R2 +15"); run(8'h1F, "R2 -1"); run(8'h70, "R2 -16");
    // R3 auto increment / decrement
    run(8'h80, "R3 inc1"); run(8'hA1, "R3 inc2"); run(8'h82, "R3 dec1"); run(8'hE3, "R3 dec2");
    // R4 accumulator offsets
    run(8'h85, "R4 B"); run(8'h86, "R4 A"); run(8'h8B, "R4 D");
    // R5 stream offsets, R6 PC-relative
    run(8'h88, "R5 ext8"); run(8'h89, "R5 ext16");
    run(8'h8C, "R6 pc8"); run(8'h8D, "R6 pc16");
    // R7 indirect forms, R8 extended indirect
    run(8'h91, "R7 inc2 ind"); run(8'hB3, "R7 dec2 ind"); run(8'h94, "R7 zero ind");
    run(8'h9C, "R7 pc8 ind"); run(8'h9F, "R8 ext ind");
    // R9 illegal encodings
    run(8'h87, "R9 n7"); run(8'h8A, "R9 nA"); run(8'h8E, "R9 nE"); run(8'h8F, "R9 nF");
    run(8'hBF, "R9 nF Y"); run(8'h90, "R9 n0 ind"); run(8'h92, "R9 n2 ind");
    // R11 wrap-around
    reg_x = 16'hFFFF; run(8'h81, "R11 inc wrap");
    reg_x = 16'h0000; run(8'h83, "R11 dec wrap");
    reg_pc = 16'hFFFF; run(8'h8D, "R11 pc wrap");
    // start ignored while busy (R10): pulse start mid-decode
    reg_pc = 16'h1234; post = 8'h99; start = 1'b1; model(8'h99);
    @(posedge clk); @(negedge clk); post = 8'h04;
    @(posedge clk); @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check("R10 busy", "ea", ea == e_ea, ea, e_ea);
    @(negedge clk);
    // random mix
    for (int k = 0; k < 600; k++) begin
      reg_x = 16'($urandom); reg_y = 16'($urandom); reg_u = 16'($urandom);
      reg_s = 16'($urandom); reg_pc = 16'($urandom);
      acc_a = 8'($urandom); acc_b = 8'($urandom);
      run(8'($urandom), "rand");
    end
    summary();
  end
endmodule